// File: doc/BRIEF.md
# Serial Slave Hold/Pause Gate

This block sits beside the shift engine of a serial slave and decides when a transaction is paused. It watches the select, serial clock and pause inputs. Those inputs are sampled on the system clock and are assumed to be synchronized already. From them it produces a pause flag, gated one-cycle strobes for the serial clock edges, and a bit/word position tracker that freezes while the pause is in force. Downstream shift and command logic uses only the gated strobes, so serial clock activity during a pause moves nothing.

A pause starts or ends only when the pause input is seen at its new level while the serial clock is low. If the pause input changes while the serial clock is high, the change waits until the clock is low again. A low pulse that falls entirely inside a clock-high phase is never acted on. While paused, the serial output enable is forced off, incoming data strobes are suppressed, and the bit and word position hold their values. When the pause ends, counting picks up from exactly those values. Deselecting the slave ends any pause and returns the position to zero.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While `rst_n` is low, `hold_active`, `so_oe`, `sample_pulse` and `drive_pulse` are 0, and `bit_idx` and `word_cnt` are 0 after reset.
- R2: `hold_active` becomes 1 on the clock after a sample in which `cs_n`=0, `hold_n`=0 and `sck`=0.
- R3: While selected and paused, `hold_active` becomes 0 on the clock after a sample in which `hold_n`=1 and `sck`=0.
- R4: A change of `hold_n` sampled while `sck`=1 has no effect until `sck` is sampled low. A low pulse on `hold_n` that starts and ends while `sck` is high causes no pause.
- R5: While `hold_active`=1, `sample_pulse` and `drive_pulse` stay 0, and `bit_idx` and `word_cnt` keep their values, whatever `sck` does.
- R6: `so_oe` equals `so_oe_req` when `cs_n`=0 and `hold_active`=0. Otherwise it is 0.
- R7: Each rising `sck` edge seen while selected and not paused gives a one-cycle `sample_pulse` and advances `bit_idx`. After `BITS_PER_WORD`-1 (default 7), `bit_idx` wraps to 0 and `word_cnt` advances. Each falling `sck` edge in the same conditions gives a one-cycle `drive_pulse`.
- R8: After a pause ends, `bit_idx` and `word_cnt` continue from the values they held when the pause began.
- R9: A sample with `cs_n`=1 clears `hold_active`, `bit_idx` and `word_cnt` on the next clock. This takes priority over any `hold_n` level in the same sample, and no pause can start while `cs_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Slave select, active low, synchronized |
| sck | input | 1 | Serial clock level, synchronized |
| hold_n | input | 1 | Pause request, active low, synchronized |
| so_oe_req | input | 1 | Output enable requested by the shift engine |
| hold_active | output | 1 | Transaction is paused |
| so_oe | output | 1 | Gated serial output enable |
| sample_pulse | output | 1 | Gated rising-edge strobe for capturing input data |
| drive_pulse | output | 1 | Gated falling-edge strobe for launching output data |
| bit_idx | output | $clog2(BITS_PER_WORD) | Bit position within the current word |
| word_cnt | output | WORD_CNT_W | Number of completed words, wrapping |

## Verification
Two functions can meet in one sample. A deselect can arrive together with a pause release, and a deselect can arrive while the pause input is still low. The bench raises `cs_n` and `hold_n` at the same clock edge while paused, and then holds `hold_n` low with `sck` low while deselected. It expects the pause flag and both counters to be zero on the next clock, and expects them to stay there. A second overlap is a serial clock edge that lands while the pause is being entered or left under a deferred request. Here the bench counts strobes and compares the frozen and resumed positions against its own model.

// File: rtl/spi_hold_pkg.sv
// Package: shared types for the serial hold gate.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_hold_pkg;
    typedef enum logic {
        HS_RUN    = 1'b0,
        HS_PAUSED = 1'b1
    } hold_state_e;
endpackage

// File: rtl/spi_hold_edge.sv
// Module: spi_hold_edge
// Detects rising and falling edges of a synchronized serial clock level.
// Assumes: sck is already synchronized to clk; reset level of sck is 0.
module spi_hold_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_prev;

    // Keep last sampled clock level, tracked even when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck;
    end

    // Raw edge strobes, one system cycle long.
    always_comb begin
        sck_rise = sck & ~sck_prev;
        sck_fall = ~sck & sck_prev;
    end
endmodule

// File: rtl/spi_hold_fsm.sv
// Module: spi_hold_fsm
// Pause state: enters/leaves only when the pause level is seen with sck low.
// Assumes: synchronized inputs; select release overrides everything.
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic hold_active
);
    hold_state_e state_q, state_d;

    // Next-state choice with deselect priority and sck-low qualification.
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = HS_RUN;
        end else if (!sck) begin
            if (state_q == HS_RUN && !hold_n)
                state_d = HS_PAUSED;
            else if (state_q == HS_PAUSED && hold_n)
                state_d = HS_RUN;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_RUN;
        else        state_q <= state_d;
    end

    assign hold_active = (state_q == HS_PAUSED);
endmodule

// File: rtl/spi_hold_seq.sv
// Module: spi_hold_seq
// Bit and word position tracker advanced by a gated strobe.
// Assumes: adv is already gated by select and pause; clr has priority.
module spi_hold_seq #(
    parameter int BITS_PER_WORD = 8,
    parameter int WORD_CNT_W    = 8,
    localparam int IDX_W        = (BITS_PER_WORD > 1) ? $clog2(BITS_PER_WORD) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  adv,
    output logic [IDX_W-1:0]      bit_idx,
    output logic [WORD_CNT_W-1:0] word_cnt
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS_PER_WORD - 1);

    // Position counters: clear on deselect, step on each gated edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_idx  <= '0;
            word_cnt <= '0;
        end else if (adv) begin
            if (bit_idx == LAST_IDX) begin
                bit_idx  <= '0;
                word_cnt <= word_cnt + 1'b1;
            end else begin
                bit_idx  <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_hold_ctrl.sv
// Module: spi_hold_ctrl (top)
// Gates serial-clock strobes and output enable under a pause request so a
// transaction can be suspended and resumed without losing its position.
// Assumes: cs_n, sck, hold_n are synchronized to clk; reset is synchronous.
module spi_hold_ctrl #(
    parameter int BITS_PER_WORD = 8,
    parameter int WORD_CNT_W    = 8,
    localparam int IDX_W        = (BITS_PER_WORD > 1) ? $clog2(BITS_PER_WORD) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sck,
    input  logic                  hold_n,
    input  logic                  so_oe_req,
    output logic                  hold_active,
    output logic                  so_oe,
    output logic                  sample_pulse,
    output logic                  drive_pulse,
    output logic [IDX_W-1:0]      bit_idx,
    output logic [WORD_CNT_W-1:0] word_cnt
);
    logic sck_rise, sck_fall, run_ok;

    spi_hold_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_hold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .hold_n      (hold_n),
        .hold_active (hold_active)
    );

    // Strobes and enable pass only when selected, running and out of reset.
    always_comb begin
        run_ok       = rst_n & ~cs_n & ~hold_active;
        sample_pulse = run_ok & sck_rise;
        drive_pulse  = run_ok & sck_fall;
        so_oe        = run_ok & so_oe_req;
    end

    spi_hold_seq #(
        .BITS_PER_WORD (BITS_PER_WORD),
        .WORD_CNT_W    (WORD_CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cs_n),
        .adv      (sample_pulse),
        .bit_idx  (bit_idx),
        .word_cnt (word_cnt)
    );
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
// Module: spi_hold_ctrl_chk
// Temporal checks on the hold gate, bound into every spi_hold_ctrl instance.
module spi_hold_ctrl_chk #(
    parameter int BITS_PER_WORD = 8,
    parameter int WORD_CNT_W    = 8,
    localparam int IDX_W        = (BITS_PER_WORD > 1) ? $clog2(BITS_PER_WORD) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  sck,
    input logic                  hold_n,
    input logic                  so_oe_req,
    input logic                  hold_active,
    input logic                  so_oe,
    input logic                  sample_pulse,
    input logic                  drive_pulse,
    input logic [IDX_W-1:0]      bit_idx,
    input logic [WORD_CNT_W-1:0] word_cnt
);
    // R2: a pause only begins from a selected, sck-low, pause-low sample.
    a_r2_enter_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> $past(!cs_n && !sck && !hold_n));

    // R3: a pause ends while selected only from a sck-low, pause-high sample.
    a_r3_exit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_active) && !$past(cs_n)) |-> $past(!sck && hold_n));

    // R5: no strobes while paused.
    a_r5_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!sample_pulse && !drive_pulse));

    // R5: position frozen across a paused, selected cycle.
    a_r5_pos_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !cs_n) |=> ($stable(bit_idx) && $stable(word_cnt)));

    // R6: output enable off while paused or deselected.
    a_r6_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active || cs_n) |-> !so_oe);

    // R9: deselect clears pause and position on the next clock.
    a_r9_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!hold_active && bit_idx == '0 && word_cnt == '0));

    // R1: reset state on the cycle after a reset sample.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!hold_active && bit_idx == '0 && word_cnt == '0));
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk #(
    .BITS_PER_WORD (BITS_PER_WORD),
    .WORD_CNT_W    (WORD_CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sck          (sck),
    .hold_n       (hold_n),
    .so_oe_req    (so_oe_req),
    .hold_active  (hold_active),
    .so_oe        (so_oe),
    .sample_pulse (sample_pulse),
    .drive_pulse  (drive_pulse),
    .bit_idx      (bit_idx),
    .word_cnt     (word_cnt)
);

// File: tb/spi_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_hold_ctrl_tb_top;
    localparam int BPW = 8;
    localparam int WCW = 8;

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, hold_n, so_oe_req;
    logic hold_active, so_oe, sample_pulse, drive_pulse;
    logic [2:0] bit_idx;
    logic [WCW-1:0] word_cnt;

    always #2 clk = ~clk;

    spi_hold_ctrl #(.BITS_PER_WORD(BPW), .WORD_CNT_W(WCW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .so_oe_req(so_oe_req), .hold_active(hold_active), .so_oe(so_oe),
        .sample_pulse(sample_pulse), .drive_pulse(drive_pulse),
        .bit_idx(bit_idx), .word_cnt(word_cnt)
    );

    typedef struct {
        string req;
        int    bi;
        int    wc;
        int    ha;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    int n_samp = 0, n_drv = 0;
    int mb = 0, mw = 0;
    bit paused_m = 0;
    bit done = 0;

    // Strobe counters observed at the ports.
    always @(posedge clk) begin
        if (sample_pulse) n_samp++;
        if (drive_pulse)  n_drv++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected state items and compares against outputs.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.req, " bit_idx"}, int'(bit_idx), e.bi);
            chk({e.req, " word_cnt"}, int'(word_cnt), e.wc);
            chk({e.req, " hold_active"}, int'(hold_active), e.ha);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_adv();
        mb++;
        if (mb == BPW) begin
            mb = 0;
            mw = (mw + 1) % (1 << WCW);
        end
    endtask

    // Driver: push the expected state, then hold inputs while it is compared.
    task automatic expect_state(input string req);
        exp_t e;
        e.req = req; e.bi = mb; e.wc = mw; e.ha = paused_m;
        q.push_back(e);
        step(2);
    endtask

    task automatic sck_pulse();
        sck = 1'b1; step(2);
        if (!paused_m) model_adv();
        sck = 1'b0; step(2);
    endtask

    initial begin
        int s0, d0;
        rst_n = 0; cs_n = 1; sck = 0; hold_n = 1; so_oe_req = 1;
        step(3);
        chk("R1 reset hold", hold_active, 0);
        chk("R1 reset oe", so_oe, 0);
        chk("R1 reset bit", bit_idx, 0);
        rst_n = 1; step(2);

        cs_n = 0; step(2);
        chk("R6 oe follows req", so_oe, 1);
        repeat (3) sck_pulse();
        expect_state("R7 count 3");
        chk("R7 sample strobes", n_samp, 3);
        chk("R7 drive strobes", n_drv, 3);

        hold_n = 0; step(2); paused_m = 1;
        expect_state("R2 enter pause");
        chk("R6 oe off paused", so_oe, 0);
        s0 = n_samp; d0 = n_drv;
        repeat (5) sck_pulse();
        chk("R5 no sample strobe", n_samp, s0);
        chk("R5 no drive strobe", n_drv, d0);
        expect_state("R5 frozen");

        hold_n = 1; step(2); paused_m = 0;
        expect_state("R3 leave pause");
        repeat (7) sck_pulse();
        expect_state("R8 resume and R7 wrap");

        // Deferred entry.
        sck = 1; step(2); model_adv();
        hold_n = 0; step(2);
        chk("R4 entry deferred", hold_active, 0);
        sck = 0; step(2);
        chk("R4 entry when sck low", hold_active, 1);
        paused_m = 1;
        // Deferred exit.
        sck = 1; step(2);
        hold_n = 1; step(2);
        chk("R4 exit deferred", hold_active, 1);
        sck = 0; step(2);
        chk("R4 exit when sck low", hold_active, 0);
        paused_m = 0;
        // Glitch inside sck high.
        sck = 1; step(2); model_adv();
        hold_n = 0; step(2);
        hold_n = 1; step(2);
        sck = 0; step(2);
        expect_state("R4 glitch ignored");

        // Deselect during pause.
        hold_n = 0; step(2); paused_m = 1;
        expect_state("R2 paused again");
        cs_n = 1; step(2);
        mb = 0; mw = 0; paused_m = 0;
        expect_state("R9 deselect clears");
        hold_n = 1;
        cs_n = 0; step(2);
        repeat (2) sck_pulse();
        hold_n = 0; step(2); paused_m = 1;
        expect_state("R2 paused before overlap");
        // Deselect and release in the same sample.
        cs_n = 1; hold_n = 1; step(2);
        mb = 0; mw = 0; paused_m = 0;
        expect_state("R9 same-cycle deselect");
        chk("R6 oe off deselected", so_oe, 0);
        hold_n = 0; step(3);
        chk("R9 no pause deselected", hold_active, 0);

        step(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule